// File: doc/BRIEF.md
# Capture Delay Tap Calibration Sequencer

This block tunes the sampling point of a converter's parallel data capture. It steps an input delay line through each of its taps and, at every tap, checks the converter's ramp test output. The I lane is checked first and then the Q lane. While one lane sends the ramp, the other lane is forced to all ones. A tap counts as good only when the external ramp checker reports lock and no error on both lanes. The sequencer collects consecutive good taps into a window and then loads the middle of that window into the delay line.

A sweep stops early when a bad tap closes a window that is wide enough. A window that is too short is dropped and the search goes on. If a sweep ends without a usable window, the sequencer waits and sweeps once more. When the search finishes, both lanes go back to normal mode and the checker is switched off. The sequencer then holds either the chosen tap or one of two failure flags until the next start.

Top module: `cap_tap_cal`

## Requirements
- R1: After start, taps are loaded in ascending order from 0. Each load sets `tap_val` and raises `tap_load` for exactly one cycle.
- R2: At each tap the I lane is tested first and the Q lane second. Mode codes are 0 normal, 1 ramp and 2 all ones. The lane under test is on ramp and the other lane is on all ones.
- R3: `chk_en` goes low for at least one cycle before each lane test. It then stays high for `DWELL` cycles, and the lane result is sampled in the last of those cycles.
- R4: A tap is good only if both lanes reported locked with no error. A lane that is not locked counts as bad.
- R5: The first good tap opens a window and each following good tap moves its stop up. A bad tap ends the sweep if stop minus start is at least `MIN_WIN` (4), and otherwise drops the window. A window still open at the last tap is kept.
- R6: If a sweep ends with no window, or with a window narrower than `MIN_WIN`, the sequencer waits `WAIT_CYC` cycles and sweeps again. At most `MAX_PASSES` (2) sweeps are run.
- R7: On success `final_tap` = (start + stop) / 2, truncated. It is loaded with one more `tap_load` pulse.
- R8: While `done` is high, both modes are 0 (normal) and `chk_en` is low. `done`, `final_tap` and the flags hold until the next start.
- R9: When the last sweep ends with no window, `fail_noconv` is set. When it ends with a window that is too narrow, `fail_narrow` is set. On failure `final_tap` is 0 and no final load is made.
- R10: Reset gives `done`, both flags, `tap_load` and `chk_en` low, and both modes normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin calibration (accepted when idle or done) |
| tap_val | output | $clog2(NUM_TAPS) | Tap value for the delay line |
| tap_load | output | 1 | One-cycle strobe that loads `tap_val` |
| i_mode | output | 2 | I lane test mode (0 normal, 1 ramp, 2 ones) |
| q_mode | output | 2 | Q lane test mode |
| chk_en | output | 1 | Ramp checker enable |
| i_locked | input | 1 | Checker lock, I lane |
| i_err | input | 1 | Checker error, I lane |
| q_locked | input | 1 | Checker lock, Q lane |
| q_err | input | 1 | Checker error, Q lane |
| final_tap | output | $clog2(NUM_TAPS) | Chosen tap (0 on failure) |
| done | output | 1 | Result valid |
| fail_noconv | output | 1 | No window found |
| fail_narrow | output | 1 | Window narrower than `MIN_WIN` |

## Verification
The bench stands in for the converter and the checker. The checker model reports lock only after the enable has been high for most of the dwell, and it answers only for the lane that is on ramp. Bad taps alternate between an unlocked I lane and a Q lane error, so every pattern tests both lanes.

The good-tap masks cover several cases:
- a single mid-range window;
- every tap good;
- a short window followed by a wide one;
- a window exactly four wide;
- a window still open at tap 31;
- a wide window after the early stop, which must be ignored;
- first-pass failures that recover, or do not recover, on the second pass.

The count of loads for each mask shows whether the sweep stopped early, and the final tap shows which window the midpoint was taken from.

// File: rtl/cap_tap_cal.sv
module cap_tap_cal #(
  parameter int NUM_TAPS   = 32,
  parameter int MIN_WIN    = 4,
  parameter int MAX_PASSES = 2,
  parameter int DWELL      = 2000000,
  parameter int WAIT_CYC   = 400000000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  output logic [$clog2(NUM_TAPS)-1:0] tap_val,
  output logic                        tap_load,
  output logic [1:0]                  i_mode,
  output logic [1:0]                  q_mode,
  output logic                        chk_en,
  input  logic                        i_locked,
  input  logic                        i_err,
  input  logic                        q_locked,
  input  logic                        q_err,
  output logic [$clog2(NUM_TAPS)-1:0] final_tap,
  output logic                        done,
  output logic                        fail_noconv,
  output logic                        fail_narrow
);
  localparam int TW = $clog2(NUM_TAPS);
  localparam int CW = $clog2((DWELL > WAIT_CYC ? DWELL : WAIT_CYC) + 1);
  localparam int PW = $clog2(MAX_PASSES + 1);
  localparam logic [1:0] M_NORM = 2'd0, M_RAMP = 2'd1, M_ONES = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_LD_HI, S_LD_LO, S_OFF, S_DWELL, S_EVAL,
    S_END, S_WAIT, S_FIN_HI, S_FIN_LO, S_DONE
  } state_t;

  state_t          st;
  logic [TW-1:0]   tap, w_lo, w_hi;
  logic [CW-1:0]   cnt;
  logic [PW-1:0]   pass_idx;
  logic            lane, i_ok, win_open;

  wire             q_ok    = q_locked && !q_err;
  wire [TW:0]      w_len   = {1'b0, w_hi} - {1'b0, w_lo};
  wire [TW:0]      w_sum   = {1'b0, w_hi} + {1'b0, w_lo};
  wire             wide    = w_len >= (TW+1)'(MIN_WIN);
  wire             testing = (st == S_OFF) || (st == S_DWELL);

  assign tap_load = (st == S_LD_HI) || (st == S_FIN_HI);
  assign tap_val  = (st == S_FIN_HI || st == S_FIN_LO) ? final_tap : tap;
  assign chk_en   = (st == S_DWELL);
  assign i_mode   = !testing ? M_NORM : (lane ? M_ONES : M_RAMP);
  assign q_mode   = !testing ? M_NORM : (lane ? M_RAMP : M_ONES);
  assign done     = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; tap <= '0; w_lo <= '0; w_hi <= '0; cnt <= '0;
      pass_idx <= '0; lane <= 1'b0; i_ok <= 1'b0; win_open <= 1'b0;
      final_tap <= '0; fail_noconv <= 1'b0; fail_narrow <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          st <= S_LD_HI; tap <= '0; lane <= 1'b0; win_open <= 1'b0;
          pass_idx <= '0; final_tap <= '0;
          fail_noconv <= 1'b0; fail_narrow <= 1'b0;
        end
        S_LD_HI: st <= S_LD_LO;
        S_LD_LO: begin st <= S_OFF; lane <= 1'b0; end
        S_OFF:   begin st <= S_DWELL; cnt <= '0; end
        S_DWELL: if (cnt == CW'(DWELL - 1)) begin
          if (!lane) begin
            i_ok <= i_locked && !i_err; lane <= 1'b1; st <= S_OFF;
          end else begin
            i_ok <= i_ok && q_ok; st <= S_EVAL;
          end
        end else cnt <= cnt + 1'b1;
        S_EVAL: begin
          if (i_ok) begin
            if (!win_open) begin win_open <= 1'b1; w_lo <= tap; end
            w_hi <= tap;
          end else if (win_open && !wide) win_open <= 1'b0;
          if ((!i_ok && win_open && wide) || tap == TW'(NUM_TAPS - 1))
            st <= S_END;
          else begin tap <= tap + 1'b1; st <= S_LD_HI; end
        end
        S_END:
          if (win_open && wide) begin
            final_tap <= w_sum[TW:1]; st <= S_FIN_HI;
          end else if (pass_idx < PW'(MAX_PASSES - 1)) begin
            pass_idx <= pass_idx + 1'b1; cnt <= '0; st <= S_WAIT;
          end else begin
            fail_noconv <= !win_open; fail_narrow <= win_open; st <= S_DONE;
          end
        S_WAIT: if (cnt == CW'(WAIT_CYC - 1)) begin
          tap <= '0; win_open <= 1'b0; st <= S_LD_HI;
        end else cnt <= cnt + 1'b1;
        S_FIN_HI: st <= S_FIN_LO;
        S_FIN_LO: st <= S_DONE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  // R1
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_load |=> !tap_load);
  // R2
  lane_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i_mode == M_RAMP) == (q_mode == M_ONES) && (q_mode == M_RAMP) == (i_mode == M_ONES));
  // R3
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_en) |-> ((i_mode == M_RAMP) != (q_mode == M_RAMP)));
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (i_mode == M_NORM && q_mode == M_NORM && !chk_en && !tap_load));
  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(final_tap) && $stable(fail_noconv) && $stable(fail_narrow)));
  // R9
  one_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail_noconv && fail_narrow));
endmodule

// File: tb/test_cap_tap_cal.sv
module test_cap_tap_cal;
  localparam int NV = 10;
  localparam logic [31:0] P1 [NV] = '{32'h001FFC00, 32'hFFFFFFFF, 32'h0003F038, 32'h00000000,
    32'h00000000, 32'hF0000000, 32'h00700780, 32'hF8000000, 32'h7FFF83E0, 32'h80000000};
  localparam logic [31:0] P2 [NV] = '{32'h0, 32'h0, 32'h0, 32'h00001F00,
    32'h00000000, 32'hE0000000, 32'h0000001F, 32'h0, 32'h0, 32'h00001FE0};
  localparam int EXP_TAP [NV] = '{15, 15, 14, 10, 0, 0, 2, 29, 7, 8};
  localparam int EXP_NC  [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 0};
  localparam int EXP_NAR [NV] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 0};
  localparam int EXP_PAS [NV] = '{1, 1, 1, 2, 2, 2, 2, 1, 1, 2};
  localparam int EXP_LDS [NV] = '{23, 33, 20, 47, 64, 64, 39, 33, 12, 47};

  logic clk = 0, rst_n = 0, start = 0;
  logic [4:0] tap_val, final_tap;
  logic [1:0] i_mode, q_mode;
  logic tap_load, chk_en, i_locked, i_err, q_locked, q_err, done, fail_noconv, fail_narrow;
  int checks = 0, fails = 0;
  int pass_cnt = 0, load_cnt = 0, hi_cnt = 0, bad_mode = 0, base = 0, vsel = 0;
  logic [4:0] ld_tap = 0;
  logic [31:0] mask;
  logic good;

  always #5 clk = ~clk;

  cap_tap_cal #(.DWELL(8), .WAIT_CYC(20)) i_cap_tap_cal (
    .clk, .rst_n, .start, .tap_val, .tap_load, .i_mode, .q_mode, .chk_en,
    .i_locked, .i_err, .q_locked, .q_err, .final_tap, .done, .fail_noconv, .fail_narrow);

  always_ff @(posedge clk) begin
    if (tap_load) begin
      ld_tap <= tap_val; load_cnt <= load_cnt + 1;
      if (tap_val == 0) pass_cnt <= pass_cnt + 1;
    end
    hi_cnt <= chk_en ? hi_cnt + 1 : 0;
    if ((i_mode == 2'd1 && q_mode != 2'd2) || (q_mode == 2'd1 && i_mode != 2'd2))
      bad_mode <= bad_mode + 1;
  end

  always_comb begin
    mask     = (pass_cnt - base <= 1) ? P1[vsel] : P2[vsel];
    good     = mask[ld_tap];
    i_locked = (i_mode == 2'd1) && hi_cnt >= 6 && (good || ld_tap[0]);
    i_err    = 1'b0;
    q_locked = (q_mode == 2'd1) && hi_cnt >= 6;
    q_err    = q_locked && !good && ld_tap[0];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic run_vec(input int v);
    int l0, t;
    vsel = v; base = pass_cnt; l0 = load_cnt;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, "watchdog R6", t, 20000);
    chk(final_tap == 5'(EXP_TAP[v]), "R7 final tap", final_tap, EXP_TAP[v]);
    chk(fail_noconv == EXP_NC[v] && fail_narrow == EXP_NAR[v], "R9 flags",
        {fail_noconv, fail_narrow}, EXP_NC[v] * 2 + EXP_NAR[v]);
    chk(pass_cnt - base == EXP_PAS[v], "R6 passes", pass_cnt - base, EXP_PAS[v]);
    chk(load_cnt - l0 == EXP_LDS[v], "R1 R5 loads", load_cnt - l0, EXP_LDS[v]);
    if (EXP_NC[v] == 0 && EXP_NAR[v] == 0)
      chk(ld_tap == final_tap, "R7 loaded tap", ld_tap, final_tap);
    chk(i_mode == 0 && q_mode == 0 && !chk_en, "R8 normal at done", {i_mode, q_mode, chk_en}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10
    chk(!done && !fail_noconv && !fail_narrow && !tap_load && !chk_en && i_mode == 0 && q_mode == 0,
        "R10 reset", {done, tap_load, chk_en}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int v = 0; v < NV; v++) run_vec(v);
    // R8: result held while start stays low
    repeat (30) @(negedge clk);
    chk(done && final_tap == 5'd8, "R8 hold", final_tap, 8);
    // R2 R3 R4: lane pairing seen by checker model
    chk(bad_mode == 0, "R2 R3 R4 lane modes", bad_mode, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog R6 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule